// File: doc/BRIEF.md
# Indexed Codec Control Registers

This block is the host-side register front end of an audio codec. The host reaches it through four byte-wide direct locations selected by two address bits. One location holds an index pointer. A second reads and writes the indirect 8-bit control register that the pointer selects. A third is a status byte carrying the interrupt flag. The fourth is a programmed-I/O data slot that reads as zero.

The pointer reaches either 16 or 32 indirect registers, depending on an extended-mode bit. Writes follow per-register rules:

- The sample-format register is guarded by a mode-change-enable handshake.
- A configuration register drops a reserved bit.
- Read-only and reserved slots ignore writes.
- The mode register accepts only its extended-mode bit.

A calibration-in-progress flag is shown for a configurable number of reads of the initialization register, after mode-change-enable is raised.

The block drives playback enable, interrupt enable and the format byte to a playback engine. It takes back a one-cycle pulse that raises the playback interrupt. A write to the status location, or clearing the playback-interrupt flag in the alternate status register, acknowledges the interrupt.

Top module: `codec_ctrl_regs`

## Requirements
- R1: `addr_i` selects the direct location: 0 is the index pointer, 1 is the indirect data, 2 is status, 3 is programmed-I/O data. Status reads return `{7'b0, irq}`. Location 3 always reads 0x00, and writes to it change nothing.
- R2: A write to location 0 stores the value with bit 7 forced to 0, so reads of location 0 never show bit 7 set. The pointer resets to 0x40, which means mode-change-enable (pointer bit 6) is set out of reset.
- R3: The indirect index is pointer[3:0] while bit 6 of register 12 is 0, and pointer[4:0] while it is 1. Writes to register 12 change only its bit 6.
- R4: Out of reset the indirect registers hold these values; all others hold 0x00:
  - 2–5, 18 and 19: 0x88
  - 6 and 7: 0x80
  - 9: 0x08
  - 12: 0x8A
  - 25 and 26: 0xA0
- R5: A write to register 8 (format) behaves as follows:
  - With mode-change-enable set, it takes the whole byte.
  - Otherwise, with bit 4 of register 24 set, it takes only bits 7:4 and keeps bits 3:0.
  - Otherwise it is ignored.
- R6: Writes to register 9 store the value with bit 5 cleared. Writes to registers 11, 22, 27 and 29 are ignored, and those registers read 0x00 (apart from the R7 flag on register 11).
- R7: When a pointer write raises mode-change-enable from 0 to 1 while bit 3 or bit 4 of register 9 is set, a counter is loaded with `CAL_READS`. Each read of register 11 while the counter is nonzero returns bit 5 set and decrements the counter. Once the counter is zero, bit 5 reads 0.
- R8: Any write to location 2 clears the status interrupt bit and bits 6:4 of register 24.
- R9: A write to register 24 with bit 4 at 0, while bit 4 was 1, clears the status interrupt bit. A write that leaves bit 4 at 1 does not clear it.
- R10: A `play_irq_set_i` pulse sets the status interrupt bit and bit 4 of register 24 on the next clock. This set wins over any clear in the same cycle.
- R11: `play_en_o` is bit 0 of register 9, `irq_en_o` is bit 1 of register 10, `fmt_o` is register 8, and `irq_o` is the status interrupt bit. `irq_o` rises only after a set pulse.
- R12: `rdata_o` is updated on the clock edge that samples `rd_i`. It holds its value on cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Direct location select |
| wr_i | input | 1 | Single-cycle write strobe |
| rd_i | input | 1 | Single-cycle read strobe |
| wdata_i | input | 8 | Write data |
| play_irq_set_i | input | 1 | Playback interrupt set pulse from the engine |
| rdata_o | output | 8 | Registered read data |
| play_en_o | output | 1 | Playback enable to the engine |
| irq_en_o | output | 1 | Interrupt enable to the engine |
| fmt_o | output | 8 | Current format register |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with `CAL_READS` set to 3. With that value, the countdown of the calibration flag shows over several consecutive reads, and its expiry can be told apart from the load itself. The default of 1 is covered by elaboration only.

The register count is fixed at 32, so both index widths are reachable:
- Registers 24–26 are reached only after the extended-mode bit is set.
- Clearing the extended-mode bit again aliases index 25 back onto register 9.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int unsigned DW    = 8;
  localparam int unsigned NREG  = 32;
  localparam int unsigned IDX_W = $clog2(NREG);

  typedef logic [DW-1:0] byte_t;

  typedef enum logic [1:0] {
    LOC_INDEX  = 2'd0,
    LOC_DATA   = 2'd1,
    LOC_STATUS = 2'd2,
    LOC_PIO    = 2'd3
  } loc_e;

  localparam int unsigned IX_FMT   = 8;
  localparam int unsigned IX_IFACE = 9;
  localparam int unsigned IX_PIN   = 10;
  localparam int unsigned IX_INIT  = 11;
  localparam int unsigned IX_MODE  = 12;
  localparam int unsigned IX_ALT   = 24;

  localparam int unsigned MCE_BIT  = 6;
  localparam int unsigned EXT_BIT  = 6;
  localparam int unsigned PMCE_BIT = 4;
  localparam int unsigned CAL_BIT  = 5;

  function automatic byte_t reset_value(int unsigned i);
    case (i)
      2, 3, 4, 5, 18, 19: return 8'h88;
      6, 7:               return 8'h80;
      9:                  return 8'h08;
      12:                 return 8'h8A;
      25, 26:             return 8'hA0;
      default:            return 8'h00;
    endcase
  endfunction

  function automatic bit is_locked(int unsigned i);
    return (i == 11) || (i == 22) || (i == 27) || (i == 29);
  endfunction
endpackage

// File: rtl/ccr_index_reg.sv
module ccr_index_reg
  import ccr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-2:0] wdata_i,
  input  logic          cal_arm_i,
  output byte_t         idx_o,
  output logic          cal_load_o
);
  byte_t idx_q;

  // calibration arms only on a 0->1 edge of mode-change-enable
  assign cal_load_o = wr_i && !idx_q[MCE_BIT] && wdata_i[MCE_BIT] && cal_arm_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   idx_q <= 8'h40;
    else if (wr_i) idx_q <= {1'b0, wdata_i};
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/ccr_cal_flag.sv
module ccr_cal_flag #(
  parameter int unsigned CAL_READS = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic take_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(CAL_READS + 1);

  logic [CW-1:0] cnt_q;

  assign busy_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= CW'(CAL_READS);
    else if (take_i && busy_o)  cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/ccr_indirect_file.sv
module ccr_indirect_file
  import ccr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] sel_i,
  input  byte_t            wdata_i,
  input  logic             mce_i,
  input  logic             clr_flags_i,
  input  logic             set_pi_i,
  output byte_t            regs_o [NREG],
  output logic             pi_drop_o
);
  logic pmce;
  assign pmce = regs_o[IX_ALT][PMCE_BIT];

  assign pi_drop_o = wr_i && (sel_i == IDX_W'(IX_ALT))
                     && regs_o[IX_ALT][PMCE_BIT] && !wdata_i[PMCE_BIT];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (is_locked(i)) begin : g_lock
      assign regs_o[i] = reset_value(i);
    end else if (i == IX_FMT) begin : g_fmt
      byte_t q;
      logic  hit;
      assign hit = wr_i && (sel_i == IDX_W'(i));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= reset_value(i);
        else if (hit) begin
          if (mce_i)     q <= wdata_i;
          else if (pmce) q <= {wdata_i[7:4], q[3:0]};
        end
      end
      assign regs_o[i] = q;
    end else if (i == IX_IFACE) begin : g_iface
      byte_t q;
      logic  hit;
      assign hit = wr_i && (sel_i == IDX_W'(i));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  q <= reset_value(i);
        else if (hit) q <= wdata_i & ~8'h20;
      end
      assign regs_o[i] = q;
    end else if (i == IX_MODE) begin : g_mode
      byte_t q;
      logic  hit;
      assign hit = wr_i && (sel_i == IDX_W'(i));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  q <= reset_value(i);
        else if (hit) q <= {q[7], wdata_i[EXT_BIT], q[5:0]};
      end
      assign regs_o[i] = q;
    end else if (i == IX_ALT) begin : g_alt
      byte_t q;
      byte_t nxt;
      logic  hit;
      assign hit = wr_i && (sel_i == IDX_W'(i));
      always_comb begin
        nxt = q;
        if (hit)         nxt = wdata_i;
        if (clr_flags_i) nxt = nxt & ~8'h70;
        if (set_pi_i)    nxt = nxt | 8'h10; // engine set wins
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= reset_value(i);
        else         q <= nxt;
      end
      assign regs_o[i] = q;
    end else begin : g_plain
      byte_t q;
      logic  hit;
      assign hit = wr_i && (sel_i == IDX_W'(i));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  q <= reset_value(i);
        else if (hit) q <= wdata_i;
      end
      assign regs_o[i] = q;
    end
  end
endmodule

// File: rtl/ccr_irq_status.sv
module ccr_irq_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);
  logic int_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    int_q <= 1'b0;
    else if (set_i) int_q <= 1'b1;
    else if (clr_i) int_q <= 1'b0;
  end

  assign irq_o = int_q;
endmodule

// File: rtl/codec_ctrl_regs.sv
module codec_ctrl_regs
  import ccr_pkg::*;
#(
  parameter int unsigned CAL_READS = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] addr_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [7:0] wdata_i,
  input  logic       play_irq_set_i,
  output logic [7:0] rdata_o,
  output logic       play_en_o,
  output logic       irq_en_o,
  output logic [7:0] fmt_o,
  output logic       irq_o
);
  byte_t            idx;
  byte_t            regs [NREG];
  logic [IDX_W-1:0] sel;
  logic             idx_wr, data_wr, stat_wr;
  logic             cal_load, cal_take, cal_busy;
  logic             pi_drop, int_bit;
  byte_t            rd_val, rdata_q;

  assign idx_wr  = wr_i && (addr_i == LOC_INDEX);
  assign data_wr = wr_i && (addr_i == LOC_DATA);
  assign stat_wr = wr_i && (addr_i == LOC_STATUS);

  assign sel = regs[IX_MODE][EXT_BIT] ? idx[IDX_W-1:0]
                                      : {1'b0, idx[IDX_W-2:0]};

  ccr_index_reg u_index (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (idx_wr),
    .wdata_i    (wdata_i[DW-2:0]),
    .cal_arm_i  (regs[IX_IFACE][3] | regs[IX_IFACE][4]),
    .idx_o      (idx),
    .cal_load_o (cal_load)
  );

  assign cal_take = rd_i && (addr_i == LOC_DATA) && (sel == IDX_W'(IX_INIT));

  ccr_cal_flag #(.CAL_READS(CAL_READS)) u_cal (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cal_load),
    .take_i (cal_take),
    .busy_o (cal_busy)
  );

  ccr_indirect_file u_file (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (data_wr),
    .sel_i       (sel),
    .wdata_i     (wdata_i),
    .mce_i       (idx[MCE_BIT]),
    .clr_flags_i (stat_wr),
    .set_pi_i    (play_irq_set_i),
    .regs_o      (regs),
    .pi_drop_o   (pi_drop)
  );

  ccr_irq_status u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (play_irq_set_i),
    .clr_i  (stat_wr | pi_drop),
    .irq_o  (int_bit)
  );

  always_comb begin
    unique case (addr_i)
      LOC_INDEX:  rd_val = idx;
      LOC_DATA: begin
        rd_val = regs[sel];
        if (sel == IDX_W'(IX_INIT) && cal_busy) rd_val[CAL_BIT] = 1'b1;
      end
      LOC_STATUS: rd_val = {7'b0, int_bit};
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_val;
  end

  assign rdata_o   = rdata_q;
  assign play_en_o = regs[IX_IFACE][0];
  assign irq_en_o  = regs[IX_PIN][1];
  assign fmt_o     = regs[IX_FMT];
  assign irq_o     = int_bit;
endmodule

// File: rtl/ccr_checker.sv
module ccr_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] addr_i,
  input logic       wr_i,
  input logic       rd_i,
  input logic       play_irq_set_i,
  input logic [7:0] rdata_o,
  input logic [7:0] fmt_o,
  input logic       irq_o
);
  assert_pio_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_i == 2'd3 |=> rdata_o == 8'h00);

  assert_index_msb_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_i == 2'd0 |=> !rdata_o[7]);

  assert_fmt_only_data_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == 2'd1) |=> $stable(fmt_o));

  assert_status_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == 2'd2 && !play_irq_set_i |=> !irq_o);

  assert_irq_fall_by_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(wr_i));

  assert_set_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    play_irq_set_i |=> irq_o);

  assert_irq_rise_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(play_irq_set_i));

  assert_rdata_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

bind codec_ctrl_regs ccr_checker chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .addr_i         (addr_i),
  .wr_i           (wr_i),
  .rd_i           (rd_i),
  .play_irq_set_i (play_irq_set_i),
  .rdata_o        (rdata_o),
  .fmt_o          (fmt_o),
  .irq_o          (irq_o)
);

// File: tb/codec_ctrl_regs_tb_top.sv
module codec_ctrl_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CAL_N      = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0, set_pi = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata_o, fmt_o;
  logic       play_en_o, irq_en_o, irq_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  codec_ctrl_regs #(.CAL_READS(CAL_N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .play_irq_set_i(set_pi), .rdata_o(rdata_o),
    .play_en_o(play_en_o), .irq_en_o(irq_en_o), .fmt_o(fmt_o), .irq_o(irq_o)
  );

  // ---------------- reference model ----------------
  int m_idx, m_int, m_cal, m_rdata;
  int m_r [32];

  function automatic int rst_val(int i);
    if (i inside {2, 3, 4, 5, 18, 19}) return 'h88;
    if (i inside {6, 7})               return 'h80;
    if (i == 9)                        return 'h08;
    if (i == 12)                       return 'h8A;
    if (i inside {25, 26})             return 'hA0;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_idx = 'h40; m_int = 0; m_cal = 0; m_rdata = 0;
      for (int i = 0; i < 32; i++) m_r[i] = rst_val(i);
    end else begin
      int s;
      int w;
      s = (m_r[12] & 'h40) ? (m_idx % 32) : (m_idx % 16);
      w = int'(wdata);
      if (rd) begin
        case (addr)
          0: m_rdata = m_idx;
          1: begin
            m_rdata = m_r[s];
            if (s == 11 && m_cal > 0) begin
              m_rdata = m_rdata | 'h20;
              m_cal = m_cal - 1;
            end
          end
          2: m_rdata = m_int;
          default: m_rdata = 0;
        endcase
      end
      if (wr) begin
        case (addr)
          0: begin
            if (!(m_idx & 'h40) && (w & 'h40) && (m_r[9] & 'h18)) m_cal = CAL_N;
            m_idx = w & 'h7F;
          end
          1: begin
            if (s == 8) begin
              if (m_idx & 'h40)       m_r[8] = w;
              else if (m_r[24] & 'h10) m_r[8] = (w & 'hF0) | (m_r[8] & 'h0F);
            end else if (s == 9) m_r[9] = w & 'hDF;
            else if (s == 12) m_r[12] = (m_r[12] & 'hBF) | (w & 'h40);
            else if (s == 24) begin
              if ((m_r[24] & 'h10) && !(w & 'h10)) m_int = 0;
              m_r[24] = w;
            end else if (!(s inside {11, 22, 27, 29})) m_r[s] = w;
          end
          2: begin
            m_int = 0;
            m_r[24] = m_r[24] & 'h8F;
          end
          default: ;
        endcase
      end
      if (set_pi) begin
        m_int = 1;
        m_r[24] = m_r[24] | 'h10;
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if (int'(rdata_o) != m_rdata) begin
        errors++; $display("FAIL R12 rdata act=%0h exp=%0h", rdata_o, m_rdata);
      end
      checks++;
      if (int'(fmt_o) != m_r[8] || play_en_o != m_r[9][0] ||
          irq_en_o != m_r[10][1] || int'(irq_o) != m_int) begin
        errors++;
        $display("FAIL R11 outs act=%0h/%0b/%0b/%0b exp=%0h/%0b/%0b/%0d",
                 fmt_o, play_en_o, irq_en_o, irq_o, m_r[8], m_r[9][0], m_r[10][1], m_int);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input int a, input int d);
    @(negedge clk); addr = 2'(a); wdata = 8'(d); wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input int a);
    @(negedge clk); addr = 2'(a); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic rd_chk(input int a, input int exp, input string tag);
    bus_rd(a);
    chk(tag, int'(rdata_o), exp);
  endtask

  task automatic pulse_set();
    @(negedge clk); set_pi = 1'b1;
    @(negedge clk); set_pi = 1'b0;
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R4 reset state at ports
    chk("R4 fmt", int'(fmt_o), 0);
    chk("R4 irq", int'(irq_o), 0);
    chk("R4 play_en", int'(play_en_o), 0);
    rd_chk(0, 'h40, "R2 reset pointer");
    for (int i = 0; i < 16; i++) begin
      bus_wr(0, 'h40 | i);
      rd_chk(1, rst_val(i), "R4 reset value");
    end
    // R3 extended indexing
    bus_wr(0, 'h4C); bus_wr(1, 'hFF);
    rd_chk(1, 'hCA, "R3 mode only bit6");
    bus_wr(0, 'h59); rd_chk(1, 'hA0, "R4 reg25");
    bus_wr(0, 'h5A); rd_chk(1, 'hA0, "R4 reg26");
    bus_wr(0, 'h4C); bus_wr(1, 'h00);
    rd_chk(1, 'h8A, "R3 mode cleared");
    bus_wr(0, 'h59); rd_chk(1, 'h08, "R3 alias 25->9");
    // R2 bit 7 drop
    bus_wr(0, 'hC5); rd_chk(0, 'h45, "R2 bit7 cleared");
    // R7 calibration flag countdown
    bus_wr(0, 'h0B); bus_wr(0, 'h4B);
    for (int k = 0; k < CAL_N; k++) rd_chk(1, 'h20, "R7 cal busy");
    rd_chk(1, 'h00, "R7 cal expired");
    bus_wr(0, 'h49); bus_wr(1, 'h00);
    bus_wr(0, 'h0B); bus_wr(0, 'h4B);
    rd_chk(1, 'h00, "R7 not armed");
    // R6 write rules
    bus_wr(0, 'h49); bus_wr(1, 'hFF);
    rd_chk(1, 'hDF, "R6 reg9 bit5");
    chk("R11 play_en", int'(play_en_o), 1);
    bus_wr(0, 'h4B); bus_wr(1, 'hFF);
    rd_chk(1, 'h00, "R6 reg11 read-only");
    // R5 format gating
    bus_wr(0, 'h48); bus_wr(1, 'h5A);
    chk("R5 full write", int'(fmt_o), 'h5A);
    bus_wr(0, 'h08); bus_wr(1, 'hFF);
    chk("R5 ignored", int'(fmt_o), 'h5A);
    bus_wr(0, 'h0C); bus_wr(1, 'h40);
    bus_wr(0, 'h18); bus_wr(1, 'h10);
    bus_wr(0, 'h08); bus_wr(1, 'h37);
    chk("R5 upper nibble", int'(fmt_o), 'h3A);
    // R6 reserved slots
    bus_wr(0, 'h16); bus_wr(1, 'h55); rd_chk(1, 'h00, "R6 reg22");
    bus_wr(0, 'h1B); bus_wr(1, 'h55); rd_chk(1, 'h00, "R6 reg27");
    bus_wr(0, 'h1D); bus_wr(1, 'h55); rd_chk(1, 'h00, "R6 reg29");
    // R11 interrupt enable export
    bus_wr(0, 'h0A); bus_wr(1, 'h02);
    chk("R11 irq_en", int'(irq_en_o), 1);
    // R10 set pulse
    bus_wr(0, 'h18); bus_wr(1, 'h00);
    pulse_set();
    chk("R10 irq set", int'(irq_o), 1);
    rd_chk(2, 'h01, "R1 status read");
    rd_chk(1, 'h10, "R10 alt bit4");
    // R9 keep bit4 -> no clear; R8 status write
    bus_wr(1, 'h70);
    chk("R9 no drop", int'(irq_o), 1);
    bus_wr(2, 'h00);
    chk("R8 irq cleared", int'(irq_o), 0);
    rd_chk(1, 'h00, "R8 alt bits cleared");
    rd_chk(2, 'h00, "R8 status read");
    // R9 drop clears
    pulse_set();
    bus_wr(1, 'h00);
    chk("R9 drop clears", int'(irq_o), 0);
    // R10 set wins over status write
    @(negedge clk); addr = 2'd2; wr = 1'b1; set_pi = 1'b1;
    @(negedge clk); wr = 1'b0; set_pi = 1'b0;
    chk("R10 set beats status clear", int'(irq_o), 1);
    // R10 set wins over bit4 drop
    @(negedge clk); addr = 2'd1; wdata = 8'h00; wr = 1'b1; set_pi = 1'b1;
    @(negedge clk); wr = 1'b0; set_pi = 1'b0;
    chk("R10 set beats drop", int'(irq_o), 1);
    rd_chk(1, 'h10, "R10 alt after race");
    bus_wr(2, 'h00);
    // R1 PIO location
    bus_wr(3, 'hAB);
    rd_chk(3, 'h00, "R1 pio reads zero");
    rd_chk(0, 'h18, "R1 pointer untouched");
    // R12 hold without reads
    repeat (3) @(negedge clk);
    chk("R12 rdata hold", int'(rdata_o), 'h18);
    repeat (2) @(negedge clk);
    summary();
  end
endmodule